// File: doc/BRIEF.md
# Shift-Register Position Video Timing Generator

This block produces the raster timing for a display: horizontal sync, vertical sync, a display-enable window and a one-cycle frame-start pulse. It runs on the pixel clock. The pixel and line positions are not kept in binary counters. Each axis keeps its position in a 16-bit linear feedback shift register (LFSR), which keeps the counter logic shallow. Every programmed position therefore reaches the block already encoded as an LFSR state, and the generator makes only equality comparisons.

Software converts each timing value to its encoded form and presents the settings as stable inputs. The horizontal register restarts at the end of every line. The vertical register steps once per line and restarts at the end of the frame. Each sync or display window opens when its axis reaches the start mark and closes when it reaches the stop mark or when the line or frame ends. Registering the outputs keeps them aligned with one another.

Top module: `lfsr_video_timing`

## Requirements
- R1: While `rstN` is low, all four outputs are low and both position registers are loaded with the seed 0xFFFF, which stands for count 0.
- R2: A position register advances by shifting left one bit and placing in bit 0 the XOR of bits 15, 4, 2 and 1 of its old value. The encoded value for count N is the state reached after N such steps from 0xFFFF.
- R3: The horizontal position advances on every clock. After the cycle in which it equals `hEndCode` it returns to 0xFFFF, so a line lasts (decoded `hEndCode` + 1) clocks.
- R4: The vertical position advances only in the cycle that ends a line. When that line's position equals `vEndCode` it returns to 0xFFFF, so a frame has (decoded `vEndCode` + 1) lines.
- R5: Take decoded horizontal position p. `hSync` covers the positions p that satisfy p >= start and either p < stop or stop <= start. Here start and stop are the decoded `hSyncOnCode` and `hSyncOffCode`. A stop mark that is never reached closes the window at the end of the line.
- R6: `vSync` follows the same window rule over the decoded line number, using `vSyncOnCode` and `vSyncOffCode`. It closes at the end of the frame.
- R7: `dispEn` is high only for positions that lie inside both the horizontal window (`hDispOnCode` to `hDispOffCode`) and the vertical window (`vDispOnCode` to `vDispOffCode`). Each window uses the rule of R5.
- R8: `frameStart` is high for exactly one clock per frame, for pixel 0 of line 0.
- R9: All outputs are registered. In any cycle they describe the position that the registers held one clock earlier, and all outputs change on the same edge.
- R10: A window whose start mark is count 0 is already open for the first position after reset and after every wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| hEndCode | input | 16 | Encoded last pixel count of a line (total minus one) |
| hSyncOnCode | input | 16 | Encoded pixel count where horizontal sync opens |
| hSyncOffCode | input | 16 | Encoded pixel count where horizontal sync closes |
| hDispOnCode | input | 16 | Encoded pixel count where the active area opens |
| hDispOffCode | input | 16 | Encoded pixel count where the active area closes |
| vEndCode | input | 16 | Encoded last line count of a frame |
| vSyncOnCode | input | 16 | Encoded line where vertical sync opens |
| vSyncOffCode | input | 16 | Encoded line where vertical sync closes |
| vDispOnCode | input | 16 | Encoded line where the active area opens |
| vDispOffCode | input | 16 | Encoded line where the active area closes |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| dispEn | output | 1 | Display enable |
| frameStart | output | 1 | One-clock pulse at the frame origin |

## Verification
The hard cycle is the one where the end of a line (or frame) falls on the same position as a window edge. That cycle must both close the window and restart the axis. It is provoked in three ways:
- a display stop mark equal to the line total, so the mark is never reached and only the wrap closes the window;
- a sync stop mark placed before its start mark;
- a vertical window that runs to the last line.

A behavioural model keeps plain integer pixel and line counts. Every clock it compares all four outputs against the windows it derives from the decoded settings. This catches a window that leaks into the next line or a wrap that closes one cycle late. A long line of 2200 pixels checks that the encoded states stay distinct over realistic totals.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned PosWidth = 16;
  localparam logic [PosWidth-1:0] PosSeed = '1;
  localparam logic [PosWidth-1:0] PosTaps = 16'h8016;
  localparam int unsigned NumWindows = 4;

  // window slots in the datapath
  localparam int unsigned WinHSync = 0;
  localparam int unsigned WinHDisp = 1;
  localparam int unsigned WinVSync = 2;
  localparam int unsigned WinVDisp = 3;

  typedef struct packed {
    logic                  hWrap;
    logic                  vWrap;
    logic                  atOrigin;
    logic [NumWindows-1:0] markOn;
    logic [NumWindows-1:0] markOff;
  } vtgStrobes_t;
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = 16'h8016
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advance,
  input  logic [W-1:0] endCode,
  output logic [W-1:0] pos,
  output logic         atEnd
);
  logic [W-1:0] stepped;
  logic         feedBit;

  assign atEnd   = (pos == endCode);
  assign feedBit = ^(pos & TAPS);
  assign stepped = {pos[W-2:0], feedBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= SEED;
    end else if (advance) begin
      pos <= atEnd ? SEED : stepped;
    end
  end
endmodule

// File: rtl/vtg_window.sv
module vtg_window (
  input  logic clk,
  input  logic rstN,
  input  logic stepEn,
  input  logic wrapClr,
  input  logic markOn,
  input  logic markOff,
  output logic inNow
);
  logic held;

  assign inNow = markOn | (held & ~markOff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= 1'b0;
    end else if (stepEn) begin
      held <= inNow & ~wrapClr;
    end
  end
endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int unsigned W = PosWidth
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] hEndCode,
  input  logic [W-1:0] hSyncOnCode,
  input  logic [W-1:0] hSyncOffCode,
  input  logic [W-1:0] hDispOnCode,
  input  logic [W-1:0] hDispOffCode,
  input  logic [W-1:0] vEndCode,
  input  logic [W-1:0] vSyncOnCode,
  input  logic [W-1:0] vSyncOffCode,
  input  logic [W-1:0] vDispOnCode,
  input  logic [W-1:0] vDispOffCode,
  output logic [W-1:0] hPos,
  output logic [W-1:0] vPos,
  output vtgStrobes_t  strobes
);
  localparam logic [W-1:0] Seed = PosSeed[W-1:0];
  localparam logic [W-1:0] Taps = PosTaps[W-1:0];

  logic hAtEnd, vAtEnd;

  vtg_axis #(.W(W), .SEED(Seed), .TAPS(Taps)) u_hAxis (
    .clk(clk), .rstN(rstN), .advance(1'b1), .endCode(hEndCode),
    .pos(hPos), .atEnd(hAtEnd)
  );

  vtg_axis #(.W(W), .SEED(Seed), .TAPS(Taps)) u_vAxis (
    .clk(clk), .rstN(rstN), .advance(hAtEnd), .endCode(vEndCode),
    .pos(vPos), .atEnd(vAtEnd)
  );

  always_comb begin
    strobes = '0;
    strobes.hWrap    = hAtEnd;
    strobes.vWrap    = vAtEnd;
    strobes.atOrigin = (hPos == Seed) && (vPos == Seed);
    strobes.markOn[WinHSync]  = (hPos == hSyncOnCode);
    strobes.markOff[WinHSync] = (hPos == hSyncOffCode);
    strobes.markOn[WinHDisp]  = (hPos == hDispOnCode);
    strobes.markOff[WinHDisp] = (hPos == hDispOffCode);
    strobes.markOn[WinVSync]  = (vPos == vSyncOnCode);
    strobes.markOff[WinVSync] = (vPos == vSyncOffCode);
    strobes.markOn[WinVDisp]  = (vPos == vDispOnCode);
    strobes.markOff[WinVDisp] = (vPos == vDispOffCode);
  end
endmodule

// File: rtl/vtg_dp.sv
module vtg_dp
  import vtg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  vtgStrobes_t strobes,
  output logic        hSyncQ,
  output logic        vSyncQ,
  output logic        dispEnQ,
  output logic        frameQ
);
  logic [NumWindows-1:0] inWin;

  for (genvar gi = 0; gi < NumWindows; gi++) begin : g_win
    // horizontal windows step every pixel and close at line end;
    // vertical windows step at line end and close at frame end
    localparam bit IsVert = (gi == WinVSync) || (gi == WinVDisp);
    logic stepEn, wrapClr;
    if (IsVert) begin : g_v
      assign stepEn  = strobes.hWrap;
      assign wrapClr = strobes.vWrap;
    end else begin : g_h
      assign stepEn  = 1'b1;
      assign wrapClr = strobes.hWrap;
    end
    vtg_window u_win (
      .clk(clk), .rstN(rstN), .stepEn(stepEn), .wrapClr(wrapClr),
      .markOn(strobes.markOn[gi]), .markOff(strobes.markOff[gi]),
      .inNow(inWin[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hSyncQ  <= 1'b0;
      vSyncQ  <= 1'b0;
      dispEnQ <= 1'b0;
      frameQ  <= 1'b0;
    end else begin
      hSyncQ  <= inWin[WinHSync];
      vSyncQ  <= inWin[WinVSync];
      dispEnQ <= inWin[WinHDisp] & inWin[WinVDisp];
      frameQ  <= strobes.atOrigin;
    end
  end
endmodule

// File: rtl/lfsr_video_timing.sv
module lfsr_video_timing
  import vtg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PosWidth-1:0] hEndCode,
  input  logic [PosWidth-1:0] hSyncOnCode,
  input  logic [PosWidth-1:0] hSyncOffCode,
  input  logic [PosWidth-1:0] hDispOnCode,
  input  logic [PosWidth-1:0] hDispOffCode,
  input  logic [PosWidth-1:0] vEndCode,
  input  logic [PosWidth-1:0] vSyncOnCode,
  input  logic [PosWidth-1:0] vSyncOffCode,
  input  logic [PosWidth-1:0] vDispOnCode,
  input  logic [PosWidth-1:0] vDispOffCode,
  output logic                hSync,
  output logic                vSync,
  output logic                dispEn,
  output logic                frameStart
);
  logic [PosWidth-1:0] hPos, vPos;
  vtgStrobes_t         strobes;

  vtg_ctrl #(.W(PosWidth)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hEndCode(hEndCode), .hSyncOnCode(hSyncOnCode), .hSyncOffCode(hSyncOffCode),
    .hDispOnCode(hDispOnCode), .hDispOffCode(hDispOffCode),
    .vEndCode(vEndCode), .vSyncOnCode(vSyncOnCode), .vSyncOffCode(vSyncOffCode),
    .vDispOnCode(vDispOnCode), .vDispOffCode(vDispOffCode),
    .hPos(hPos), .vPos(vPos), .strobes(strobes)
  );

  vtg_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hSyncQ(hSync), .vSyncQ(vSync), .dispEnQ(dispEn), .frameQ(frameStart)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] hPos,
  input logic [W-1:0] vPos,
  input logic [W-1:0] hEndCode,
  input logic         frameStart
);
  localparam logic [W-1:0] Seed = '1;

  // R2: a maximal-style sequence started from all ones never reaches all zeros
  a_r2_no_lockup: assert property (@(posedge clk) disable iff (!rstN)
    (hPos != '0) && (vPos != '0));

  // R3: matching the end code sends the horizontal position back to the seed
  a_r3_wrap_to_seed: assert property (@(posedge clk) disable iff (!rstN)
    (hPos == hEndCode) |=> (hPos == Seed));

  // R4: the line position only moves in a cycle that ends a line
  a_r4_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hPos != hEndCode) |=> $stable(vPos));

  // R8: the frame pulse follows a cycle at the origin
  a_r8_frame_at_origin: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> ($past(hPos) == Seed) && ($past(vPos) == Seed));
endmodule

bind lfsr_video_timing vtg_checker #(.W(vtg_pkg::PosWidth)) u_chk (
  .clk(clk), .rstN(rstN), .hPos(hPos), .vPos(vPos),
  .hEndCode(hEndCode), .frameStart(frameStart)
);

// File: tb/sim_lfsr_video_timing.sv
module sim_lfsr_video_timing;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hEndCode, hSyncOnCode, hSyncOffCode, hDispOnCode, hDispOffCode;
  logic [15:0] vEndCode, vSyncOnCode, vSyncOffCode, vDispOnCode, vDispOffCode;
  logic hSync, vSync, dispEn, frameStart;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference settings as plain counts
  int hTot, hSs, hSe, hDs, hDe, vLines, vSs, vSe, vDs, vDe;
  int hc, vc;

  always #2.5 clk = ~clk;

  lfsr_video_timing u0 (
    .clk(clk), .rstN(rstN),
    .hEndCode(hEndCode), .hSyncOnCode(hSyncOnCode), .hSyncOffCode(hSyncOffCode),
    .hDispOnCode(hDispOnCode), .hDispOffCode(hDispOffCode),
    .vEndCode(vEndCode), .vSyncOnCode(vSyncOnCode), .vSyncOffCode(vSyncOffCode),
    .vDispOnCode(vDispOnCode), .vDispOffCode(vDispOffCode),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn), .frameStart(frameStart)
  );

  // R2: encoded value for count n, stepping from all ones
  function automatic logic [15:0] codeOf(int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  function automatic bit inWin(int p, int s, int e);
    return (p >= s) && ((e <= s) || (p < e));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at h=%0d v=%0d: actual=%b expected=%b", tag, hc, vc, act, exp);
    end
  endtask

  task automatic setup(int ht, int hs0, int hs1, int hd0, int hd1,
                       int vl, int vs0, int vs1, int vd0, int vd1);
    hTot = ht; hSs = hs0; hSe = hs1; hDs = hd0; hDe = hd1;
    vLines = vl; vSs = vs0; vSe = vs1; vDs = vd0; vDe = vd1;
    hEndCode = codeOf(ht - 1);
    hSyncOnCode = codeOf(hs0); hSyncOffCode = codeOf(hs1);
    hDispOnCode = codeOf(hd0); hDispOffCode = codeOf(hd1);
    vEndCode = codeOf(vl - 1);
    vSyncOnCode = codeOf(vs0); vSyncOffCode = codeOf(vs1);
    vDispOnCode = codeOf(vd0); vDispOffCode = codeOf(vd1);
  endtask

  // hold reset, check R1 quiet outputs, release on a falling edge
  task automatic restart();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 hSync in reset", hSync, 1'b0);
    check("R1 vSync in reset", vSync, 1'b0);
    check("R1 dispEn in reset", dispEn, 1'b0);
    check("R1 frameStart in reset", frameStart, 1'b0);
    rstN = 1'b1;
    hc = 0;
    vc = 0;
  endtask

  // R9: outputs after an edge describe the position held before it
  task automatic runFrames(int n);
    for (int i = 0; i < n * hTot * vLines; i++) begin
      bit eH, eV, eD, eF;
      eH = inWin(hc, hSs, hSe);
      eV = inWin(vc, vSs, vSe);
      eD = inWin(hc, hDs, hDe) && inWin(vc, vDs, vDe);
      eF = (hc == 0) && (vc == 0);
      hc++;
      if (hc == hTot) begin      // R3 line length
        hc = 0;
        vc++;                    // R4 one line step per wrap
        if (vc == vLines) vc = 0;
      end
      @(negedge clk);
      check("R5 hSync", hSync, eH);
      check("R6/R10 vSync", vSync, eV);
      check("R7 dispEn", dispEn, eD);
      check("R8 frameStart", frameStart, eF);
    end
  endtask

  initial begin
    // plain mode: front porch present, vsync from line 0 (R10)
    setup(20, 1, 4, 6, 18, 13, 0, 2, 5, 11);
    restart();
    runFrames(3);

    // coincidences: display stop equals line total, sync stop before start,
    // vertical windows that run to the last line
    setup(16, 5, 2, 8, 16, 12, 3, 3, 6, 12);
    restart();
    runFrames(3);

    // long line, display window from count 0 on both axes (R10)
    setup(2200, 1, 45, 0, 2020, 4, 0, 1, 0, 3);
    restart();
    runFrames(3);

    // reset in the middle of a frame returns to the origin (R1)
    runFrames(0);
    repeat (37) @(negedge clk);
    restart();
    runFrames(1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule